// File: doc/BRIEF.md
# Host-Bound Packet Stream Framer

This block turns packets that the switch fabric has already stored for the host port into a 128-bit beat stream. Each packet leaves in three parts. A header beat carries four 32-bit info words: a type/flow word, a length word, a fixed marker word and a source-ID word. Then come the payload beats, sixteen bytes each, with the last one possibly partial. A trailer beat carries four 32-bit status words: the two timestamp halves, the checksum result and a zero word. There is one output thread, so a packet is always finished before the next one starts.

Upstream supplies one metadata record per packet on a valid/ready handshake. The record holds the ingress port (1 to 8), the switch priority, the stored byte length (CRC included), an ingress error code, an optional flow override, the source ID, a 64-bit timestamp and the checksum status. Upstream then supplies the stored bytes as 128-bit beats on a second handshake. If CRC stripping is configured and the packet has no error, the four CRC bytes are removed from the reported length and from the stream. A beat that would hold only CRC bytes is consumed and never emitted.

The controller has five states:
- `ST_IDLE` accepts metadata and moves to `ST_INFO`.
- `ST_INFO` holds the header beat until it is taken, then moves to `ST_PAY`.
- `ST_PAY` forwards payload beats. After the last output beat it moves to `ST_STAT`, or to `ST_DROP` when input beats remain.
- `ST_DROP` swallows the remaining CRC-only input beat and then moves to `ST_STAT`.
- `ST_STAT` holds the trailer beat until it is taken, then returns to `ST_IDLE`.

Top module: `hostpkt_framer`

## Requirements
- R1: The SOP beat carries info word 0 in bits 31:0 up to info word 3 in bits 127:96. Info word 0 has the value 0b00111 in bits 31:27, the pass-CRC flag in bit 23, the CRC kind in bit 22 (0 Ethernet, 1 Castagnoli, taken from `cfg_crc_castagnoli`) and the flow ID in bits 7:0. All its other bits are zero.
- R2: The flow ID is {2'b00, (ingress port − 1) in 3 bits, priority in 3 bits}; for example, port 4 with priority 5 gives 29. When `hdr_flow_ovr_en` is 1, `hdr_flow_ovr` replaces it.
- R3: Pass-CRC is 0 only when `cfg_crc_strip` is 1 and the error code is 0; otherwise it is 1. The reported length is the stored length minus 4 when pass-CRC is 0, and the stored length otherwise.
- R4: Info word 1 is {12'h004, 6'b0, reported length}. Info word 2 is 0x0000FFFF. Info word 3 is {8'h00, source ID, 16'h0000}.
- R5: Payload beats follow the header unchanged and in order. There are ceil(reported length / 16) of them, with SOP and EOP both 0.
- R6: `out_bytes` equals the reported length mod 16 on the final payload beat, where 0 means all 16 bytes are valid. It is 0 on every other beat.
- R7: When stripping leaves fewer output beats than stored input beats, the surplus input beat is accepted and produces no output beat.
- R8: The EOP beat carries timestamp[31:0], timestamp[63:32], {11'b0, checksum status[20:0]} and zero, in words 0 to 3. `out_err` carries the ingress error code (0 = no error) on this beat only and is 0 on all other beats.
- R9: `hdr_ready` stays 0 from the cycle after the header beat is taken until the EOP beat is taken, so packets never interleave.
- R10: While `out_ready` is 0, a presented beat stays valid with its data unchanged; nothing is dropped.
- R11: After reset, `out_valid` is 0 and `hdr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Metadata record offered |
| hdr_ready | output | 1 | Metadata record accepted |
| hdr_port | input | 4 | Ingress port, 1 to 8 |
| hdr_prio | input | 3 | Switch priority |
| hdr_len | input | LEN_W | Stored byte length including CRC |
| hdr_err | input | 4 | Ingress error code, 0 = none |
| hdr_flow_ovr_en | input | 1 | Use the override flow ID |
| hdr_flow_ovr | input | 8 | Override flow ID |
| hdr_src_id | input | 8 | Source ID |
| hdr_tstamp | input | 64 | Packet timestamp |
| hdr_csum | input | 21 | Checksum flags and sum |
| cfg_crc_strip | input | 1 | Remove CRC from clean packets |
| cfg_crc_castagnoli | input | 1 | CRC kind reported in the header |
| pay_valid | input | 1 | Stored payload beat offered |
| pay_ready | output | 1 | Stored payload beat accepted |
| pay_data | input | 128 | Stored payload beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken |
| out_data | output | 128 | Output beat |
| out_sop | output | 1 | Header beat marker |
| out_eop | output | 1 | Trailer beat marker |
| out_bytes | output | 4 | Valid bytes on final payload beat, 0 = 16 |
| out_err | output | 4 | Error code on the trailer beat |

## Verification
The bench builds the block with the default `LEN_W` of 14, so the length field fills the whole 14-bit header field. The test packets stay short, from 1 to 70 bytes, so each run is brief while still reaching full and partial last beats. These lengths also reach the strip case where a whole input beat holds only CRC bytes. The cases cover ports 1, 4 and 8 for the flow arithmetic, and both clean and errored packets under stripping. Pseudo-random output stalls bring the hold-under-backpressure behaviour within reach.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INFO,
        ST_PAY,
        ST_DROP,
        ST_STAT
    } hpf_state_e;

    localparam int          WORD_W      = 32;
    localparam int          BEAT_W      = 4 * WORD_W;
    localparam int          CRC_BYTES   = 4;
    localparam int          LENFIELD_W  = 14;
    localparam logic [4:0]  PKT_TYPE_C  = 5'b00111;
    localparam logic [11:0] PS_SIZE_C   = 12'h004;
    localparam logic [31:0] MARKER_C    = 32'h0000_FFFF;
endpackage

// File: rtl/hpf_meta.sv
module hpf_meta
    import hpf_pkg::*;
#(
    parameter int LEN_W = 14,
    localparam int CNT_W = LEN_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [3:0]        port_i,
    input  logic [2:0]        prio_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [3:0]        err_i,
    input  logic              ovr_en_i,
    input  logic [7:0]        ovr_i,
    input  logic [7:0]        src_i,
    input  logic [63:0]       ts_i,
    input  logic [20:0]       csum_i,
    input  logic              cfg_strip_i,
    input  logic              cfg_kind_i,
    output logic [BEAT_W-1:0] info_beat,
    output logic [BEAT_W-1:0] stat_beat,
    output logic [3:0]        err_q,
    output logic [CNT_W-1:0]  out_beats,
    output logic [CNT_W-1:0]  in_beats,
    output logic [3:0]        tail_bytes
);
    logic [7:0]       flow_q;
    logic             pass_q;
    logic             kind_q;
    logic [7:0]       src_q;
    logic [63:0]      ts_q;
    logic [20:0]      csum_q;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       flow_d;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W:0]   in_sum;
    logic [LEN_W:0]   out_sum;

    always_comb begin
        if (ovr_en_i) flow_d = ovr_i;
        else          flow_d = {2'b00, 3'(port_i - 4'd1), prio_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flow_q <= '0;
            pass_q <= 1'b1;
            kind_q <= 1'b0;
            src_q  <= '0;
            ts_q   <= '0;
            csum_q <= '0;
            len_q  <= '0;
            err_q  <= '0;
        end else if (capture) begin
            flow_q <= flow_d;
            pass_q <= !(cfg_strip_i && (err_i == 4'd0));
            kind_q <= cfg_kind_i;
            src_q  <= src_i;
            ts_q   <= ts_i;
            csum_q <= csum_i;
            len_q  <= len_i;
            err_q  <= err_i;
        end
    end

    always_comb begin
        eff_len    = pass_q ? len_q : (len_q - LEN_W'(CRC_BYTES));
        in_sum     = {1'b0, len_q}   + (LEN_W+1)'(15);
        out_sum    = {1'b0, eff_len} + (LEN_W+1)'(15);
        in_beats   = in_sum[LEN_W:4];
        out_beats  = out_sum[LEN_W:4];
        tail_bytes = eff_len[3:0];
        info_beat  = {
            {8'h00, src_q, 16'h0000},
            MARKER_C,
            {PS_SIZE_C, 6'b0, LENFIELD_W'(eff_len)},
            {PKT_TYPE_C, 3'b000, pass_q, kind_q, 14'b0, flow_q}
        };
        stat_beat  = {32'h0, {11'b0, csum_q}, ts_q[63:32], ts_q[31:0]};
    end

    // Stripping only applies to clean packets, so an errored packet keeps its CRC
    AST_ERR_KEEPS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(capture) && ($past(err_i) != 4'd0) |-> pass_q) else $error("strip on errored"); // R3
endmodule

// File: rtl/hpf_beat_ctr.sv
module hpf_beat_ctr #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_out,
    input  logic [CNT_W-1:0] load_in,
    input  logic             dec_out,
    input  logic             dec_in,
    output logic             last_out,
    output logic             last_in
);
    logic [CNT_W-1:0] out_left;
    logic [CNT_W-1:0] in_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_left <= '0;
            in_left  <= '0;
        end else if (load) begin
            out_left <= load_out;
            in_left  <= load_in;
        end else begin
            if (dec_out) out_left <= out_left - CNT_W'(1);
            if (dec_in)  in_left  <= in_left  - CNT_W'(1);
        end
    end

    assign last_out = (out_left == CNT_W'(1));
    assign last_in  = (in_left  == CNT_W'(1));

    AST_NO_OUT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out |-> (out_left != '0)) else $error("out beat underflow"); // R5
    AST_NO_IN_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in |-> (in_left != '0)) else $error("in beat underflow"); // R7
endmodule

// File: rtl/hpf_fsm.sv
module hpf_fsm
    import hpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hdr_valid,
    input  logic pay_valid,
    input  logic out_ready,
    input  logic last_out,
    input  logic last_in,
    output logic hdr_ready,
    output logic pay_ready,
    output logic out_valid,
    output logic out_sop,
    output logic out_eop,
    output logic sel_pay,
    output logic capture,
    output logic dec_out,
    output logic dec_in
);
    hpf_state_e state_q;
    hpf_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hdr_valid) state_d = ST_INFO;
            ST_INFO: if (out_ready) state_d = ST_PAY;
            ST_PAY:  if (pay_valid && out_ready && last_out)
                         state_d = last_in ? ST_STAT : ST_DROP;
            ST_DROP: if (pay_valid && last_in) state_d = ST_STAT;
            ST_STAT: if (out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hdr_ready = 1'b0;
        pay_ready = 1'b0;
        out_valid = 1'b0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        sel_pay   = 1'b0;
        capture   = 1'b0;
        dec_out   = 1'b0;
        dec_in    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                hdr_ready = 1'b1;
                capture   = hdr_valid;
            end
            ST_INFO: begin
                out_valid = 1'b1;
                out_sop   = 1'b1;
            end
            ST_PAY: begin
                sel_pay   = 1'b1;
                out_valid = pay_valid;
                pay_ready = out_ready;
                dec_out   = pay_valid && out_ready;
                dec_in    = pay_valid && out_ready;
            end
            ST_DROP: begin
                pay_ready = 1'b1;
                dec_in    = pay_valid;
            end
            ST_STAT: begin
                out_valid = 1'b1;
                out_eop   = 1'b1;
            end
            default: ;
        endcase
    end

    AST_SOP_EOP_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_sop && out_eop)) else $error("sop and eop together"); // R8
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_ready && !out_ready) |-> !out_valid) else $error("surplus beat emitted"); // R7
endmodule

// File: rtl/hostpkt_framer.sv
module hostpkt_framer
    import hpf_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [3:0]        hdr_port,
    input  logic [2:0]        hdr_prio,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic [3:0]        hdr_err,
    input  logic              hdr_flow_ovr_en,
    input  logic [7:0]        hdr_flow_ovr,
    input  logic [7:0]        hdr_src_id,
    input  logic [63:0]       hdr_tstamp,
    input  logic [20:0]       hdr_csum,
    input  logic              cfg_crc_strip,
    input  logic              cfg_crc_castagnoli,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [127:0]      pay_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [127:0]      out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic [3:0]        out_bytes,
    output logic [3:0]        out_err
);
    localparam int CNT_W = LEN_W - 3;

    logic [BEAT_W-1:0] info_beat;
    logic [BEAT_W-1:0] stat_beat;
    logic [3:0]        err_q;
    logic [CNT_W-1:0]  out_beats;
    logic [CNT_W-1:0]  in_beats;
    logic [3:0]        tail_bytes;
    logic              sel_pay;
    logic              capture;
    logic              dec_out;
    logic              dec_in;
    logic              last_out;
    logic              last_in;
    logic              capture_q;

    hpf_meta #(.LEN_W(LEN_W)) u_meta (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .port_i(hdr_port), .prio_i(hdr_prio), .len_i(hdr_len), .err_i(hdr_err),
        .ovr_en_i(hdr_flow_ovr_en), .ovr_i(hdr_flow_ovr), .src_i(hdr_src_id),
        .ts_i(hdr_tstamp), .csum_i(hdr_csum),
        .cfg_strip_i(cfg_crc_strip), .cfg_kind_i(cfg_crc_castagnoli),
        .info_beat(info_beat), .stat_beat(stat_beat), .err_q(err_q),
        .out_beats(out_beats), .in_beats(in_beats), .tail_bytes(tail_bytes)
    );

    // Counters load one cycle after capture, when the registered length is visible
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) capture_q <= 1'b0;
        else        capture_q <= capture;
    end

    hpf_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(capture_q),
        .load_out(out_beats), .load_in(in_beats),
        .dec_out(dec_out), .dec_in(dec_in),
        .last_out(last_out), .last_in(last_in)
    );

    hpf_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .pay_valid(pay_valid),
        .out_ready(out_ready), .last_out(last_out), .last_in(last_in),
        .hdr_ready(hdr_ready), .pay_ready(pay_ready), .out_valid(out_valid),
        .out_sop(out_sop), .out_eop(out_eop), .sel_pay(sel_pay),
        .capture(capture), .dec_out(dec_out), .dec_in(dec_in)
    );

    always_comb begin
        if (out_sop)      out_data = info_beat;
        else if (out_eop) out_data = stat_beat;
        else if (sel_pay) out_data = pay_data;
        else              out_data = '0;
        out_bytes = (sel_pay && last_out) ? tail_bytes : 4'd0;
        out_err   = out_eop ? err_q : 4'd0;
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && (out_sop || out_eop)) |=> (out_valid && $stable(out_data))) else $error("beat lost on stall"); // R10
    AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_sop) |=> !hdr_ready) else $error("header accepted mid packet"); // R9
    AST_EOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> hdr_ready) else $error("not idle after eop"); // R9
    AST_BYTES_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_bytes != 4'd0) |-> (out_valid && !out_sop && !out_eop)) else $error("byte count off last beat"); // R6
    AST_ERR_ONLY_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_err != 4'd0) |-> out_eop) else $error("error code off eop"); // R8
endmodule

// File: tb/hostpkt_framer_tb.sv
module hostpkt_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 14;

    typedef struct packed {
        logic [127:0] data;
        logic         sop;
        logic         eop;
        logic [3:0]   bytes;
        logic [3:0]   err;
    } beat_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hdr_valid = 1'b0;
    logic hdr_ready;
    logic [3:0] hdr_port = '0;
    logic [2:0] hdr_prio = '0;
    logic [LEN_W-1:0] hdr_len = '0;
    logic [3:0] hdr_err = '0;
    logic hdr_flow_ovr_en = 1'b0;
    logic [7:0] hdr_flow_ovr = '0;
    logic [7:0] hdr_src_id = '0;
    logic [63:0] hdr_tstamp = '0;
    logic [20:0] hdr_csum = '0;
    logic cfg_crc_strip = 1'b0;
    logic cfg_crc_castagnoli = 1'b0;
    logic pay_valid = 1'b0;
    logic pay_ready;
    logic [127:0] pay_data = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [127:0] out_data;
    logic out_sop, out_eop;
    logic [3:0] out_bytes, out_err;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit stall_en = 1'b0;
    logic [7:0] lfsr = 8'hA7;
    beat_t exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hostpkt_framer #(.LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_port(hdr_port), .hdr_prio(hdr_prio), .hdr_len(hdr_len), .hdr_err(hdr_err),
        .hdr_flow_ovr_en(hdr_flow_ovr_en), .hdr_flow_ovr(hdr_flow_ovr),
        .hdr_src_id(hdr_src_id), .hdr_tstamp(hdr_tstamp), .hdr_csum(hdr_csum),
        .cfg_crc_strip(cfg_crc_strip), .cfg_crc_castagnoli(cfg_crc_castagnoli),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_bytes(out_bytes), .out_err(out_err)
    );

    // Output backpressure changes shortly after the rising edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = stall_en ? lfsr[0] : 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares every taken beat against the scoreboard
    beat_t prev_beat;
    bit prev_stall = 1'b0;
    always begin
        @(negedge clk);
        #3;
        if (rst_n) begin
            if (prev_stall) begin
                check(out_valid && (out_data == prev_beat.data), "R10 hold under stall",
                      out_data, prev_beat.data);
            end
            prev_stall = out_valid && !out_ready;
            prev_beat.data = out_data;
            if (out_valid && out_ready) begin
                beat_t got;
                got = '{data: out_data, sop: out_sop, eop: out_eop, bytes: out_bytes, err: out_err};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R7 unexpected beat", got.data, '0);
                end else begin
                    beat_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(got == e, t, {got.data[119:0], got.sop, got.eop, got.bytes, got.err},
                          {e.data[119:0], e.sop, e.eop, e.bytes, e.err});
                end
            end
        end
    end

    // Driver: builds expectations from the requirements, then drives both handshakes
    task automatic send_pkt(input logic [3:0] port, input logic [2:0] prio, input int len,
                            input logic [3:0] err, input bit ovr_en, input logic [7:0] ovr,
                            input logic [7:0] src, input logic [63:0] ts, input logic [20:0] cs,
                            input bit strip, input bit kind, input logic [7:0] id);
        bit pass;
        int eff, nin, nout;
        logic [7:0] flow;
        logic [31:0] w0, w1, w2, w3;
        beat_t b;
        pass = !(strip && err == 4'd0);                          // R3
        eff  = pass ? len : len - 4;
        nin  = (len + 15) / 16;
        nout = (eff + 15) / 16;
        flow = ovr_en ? ovr : {2'b00, 3'(port - 4'd1), prio};    // R2
        w0 = {5'b00111, 3'b0, pass, kind, 14'b0, flow};          // R1
        w1 = {12'h004, 6'b0, 14'(eff)};                          // R4
        w2 = 32'h0000FFFF;
        w3 = {8'h00, src, 16'h0};
        b = '{data: {w3, w2, w1, w0}, sop: 1'b1, eop: 1'b0, bytes: 4'd0, err: 4'd0};
        exp_q.push_back(b); tag_q.push_back("R1/R2/R3/R4 header beat");
        for (int i = 0; i < nout; i++) begin
            b = '{data: {4{id, 8'(i), 16'hC0DE}}, sop: 1'b0, eop: 1'b0,
                  bytes: (i == nout - 1) ? 4'(eff % 16) : 4'd0, err: 4'd0};
            exp_q.push_back(b); tag_q.push_back("R5/R6 payload beat");
        end
        b = '{data: {32'h0, {11'b0, cs}, ts[63:32], ts[31:0]}, sop: 1'b0, eop: 1'b1,
              bytes: 4'd0, err: err};
        exp_q.push_back(b); tag_q.push_back("R8/R7 trailer beat");

        hdr_port = port; hdr_prio = prio; hdr_len = LEN_W'(len); hdr_err = err;
        hdr_flow_ovr_en = ovr_en; hdr_flow_ovr = ovr; hdr_src_id = src;
        hdr_tstamp = ts; hdr_csum = cs; cfg_crc_strip = strip; cfg_crc_castagnoli = kind;
        hdr_valid = 1'b1;
        #1;
        while (!hdr_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        hdr_valid = 1'b0;
        #1;
        check(hdr_ready == 1'b0, "R9 header blocked mid packet", 128'(hdr_ready), 128'd0);
        for (int i = 0; i < nin; i++) begin
            pay_data = {4{id, 8'(i), 16'hC0DE}};
            pay_valid = 1'b1;
            #1;
            while (!pay_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        pay_valid = 1'b0;
        pay_data = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R11 reset out_valid", 128'(out_valid), 128'd0);
        check(hdr_ready == 1'b1, "R11 reset hdr_ready", 128'(hdr_ready), 128'd1);
        @(negedge clk);
        // port 4 priority 5 -> flow 29, full beats, CRC passed
        send_pkt(4'd4, 3'd5, 64, 4'd0, 1'b0, 8'h00, 8'h3C, 64'h1122334455667788, 21'h1FFFFF, 1'b0, 1'b0, 8'hA1);
        stall_en = 1'b1;
        // strip on clean packet: surplus CRC-only beat swallowed (R7)
        send_pkt(4'd2, 3'd1, 68, 4'd0, 1'b0, 8'h00, 8'h11, 64'hDEADBEEF00C0FFEE, 21'h0ABCDE, 1'b1, 1'b0, 8'hB2);
        // override flow, Castagnoli kind, partial tail of 14 bytes
        send_pkt(4'd3, 3'd2, 66, 4'd0, 1'b1, 8'hA5, 8'h7E, 64'h0, 21'h150000, 1'b1, 1'b1, 8'hC3);
        // strip requested but errored: CRC kept, error code on EOP
        send_pkt(4'd5, 3'd6, 70, 4'd1, 1'b0, 8'h00, 8'h01, 64'hFFFF0000FFFF0000, 21'h0, 1'b1, 1'b0, 8'hD4);
        // single-byte packet from port 1 priority 0
        send_pkt(4'd1, 3'd0, 1, 4'd6, 1'b0, 8'h00, 8'hFF, 64'h0123456789ABCDEF, 21'h1, 1'b0, 1'b0, 8'hE5);
        // strip leaves exactly one full beat
        send_pkt(4'd7, 3'd3, 20, 4'd0, 1'b0, 8'h00, 8'h20, 64'h5, 21'h7, 1'b1, 1'b0, 8'hF6);
        stall_en = 1'b0;
        // port 8 priority 7 -> flow 0x3F
        send_pkt(4'd8, 3'd7, 33, 4'd0, 1'b0, 8'h00, 8'h42, 64'h9, 21'h100000, 1'b0, 1'b1, 8'h17);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        #4;
        check(hdr_ready == 1'b1 && out_valid == 1'b0, "R9 idle after last eop",
              {126'd0, hdr_ready, out_valid}, 128'd2);
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end
endmodule